// File: doc/BRIEF.md
# Vectored Two-Line Interrupt Controller

This block sits on the register bus of a 32-bit processor and turns two external request lines into the processor's fast-interrupt and normal-interrupt levels. The fast line is sampled each clock. It reaches `fiq_o` only while bit 0 of the fast-enable word is set. The normal line is also sampled each clock. It reaches `irq_o` only while the 4-bit enable nibble in the upper bits of an expanded-bank word is nonzero.

Every rising edge of the normal line writes the fixed code 31 into a vector word. Software acknowledges the interrupt by reading that word. The read returns the code and then clears both the vector and the current-level word. A store to a separate clear-level word also empties the current-level word.

The register space has two banks of full 32-bit words, each decoded in its own 256-byte window. The primary bank holds 12 words and sits at 0x7800_0000. The expanded bank holds 8 words and sits at 0x7BF0_0000. Address bits [1:0] are ignored. There is no sequencing state: the block is register storage, an edge detector and combinational gating.

Top module: `vec_intc`

## Requirements
- R1: After reset `fiq_o` and `irq_o` are low and every populated word reads 0.
- R2: `fiq_o` is high exactly when primary offset 0x10 bit 0 is 1 and `fiq_in` was high at the previous clock edge.
- R3: `irq_o` is high exactly when expanded offset 0x18 bits [31:28] are nonzero and `irq3_in` was high at the previous clock edge.
- R4: A low-to-high change of the sampled `irq3_in` loads 31 into the vector word at primary offset 0x14. Holding the line high does not reload it.
- R5: A read strobe at primary offset 0x14 returns the current vector in that cycle. After that edge, both the vector word and the level word at primary offset 0x18 are 0.
- R6: A write to primary offset 0x28 stores the word there and clears the level word at offset 0x18 to 0.
- R7: A write with `bus_sel` and `bus_wr` high stores all 32 bits into the addressed word of either bank, and the word reads back unchanged.
- R8: Primary offsets 0x30 and above, expanded offsets 0x20 and above, and addresses outside both windows read as 0 and ignore writes.
- R9: Reads of words other than the vector word have no side effect. Bus cycles with `bus_sel` low neither write nor clear.
- R10: A rising edge of the line in the same cycle as a vector read leaves the vector at 31, and the level word is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, valid in the strobe cycle |
| fiq_in | input | 1 | External fast-interrupt request level |
| irq3_in | input | 1 | External normal-interrupt request level |
| fiq_o | output | 1 | Gated fast-interrupt level to the processor |
| irq_o | output | 1 | Gated normal-interrupt level to the processor |

## Verification
A corrupted enable word or a stale sampled line shows on `fiq_o` or `irq_o` one edge after the request line or the word changes. The directed tests check the outputs at that point. A missed clear or a missing load in the vector path is invisible until the next acknowledge read. For that reason the tests read the vector and level words right after each event, and then read them again. A misdecoded address shows up as a nonzero read from an empty slot, or as a word that changes when a different slot is written.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
    localparam int DATA_W     = 32;
    localparam int WIN_BITS   = 8;
    localparam int PRI_WORDS  = 12;
    localparam int EXP_WORDS  = 8;
    localparam int FIQ_EN_IDX = 4;
    localparam int VEC_IDX    = 5;
    localparam int LVL_IDX    = 6;
    localparam int CLR_IDX    = 10;
    localparam int IRQ_EN_IDX = 6;
    localparam logic [DATA_W-1:0] VEC_CODE = 32'd31;
endpackage

// File: rtl/vec_intc_decode.sv
module vec_intc_decode #(
    parameter logic [31:0] BASE     = 32'h7800_0000,
    parameter int          WIN_BITS = 8,
    parameter int          WORDS    = 12,
    localparam int         IDX_W    = WIN_BITS - 2
) (
    input  logic [31:0]      addr,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    logic hit;

    always_comb begin
        hit   = (addr[31:WIN_BITS] == BASE[31:WIN_BITS]);
        idx   = addr[WIN_BITS-1:2];
        valid = hit && (int'(idx) < WORDS);
    end
endmodule

// File: rtl/vec_intc_regbank.sv
module vec_intc_regbank #(
    parameter int  WORDS  = 12,
    parameter int  DATA_W = 32,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [WORDS-1:0]              clr_mask,
    input  logic [WORDS-1:0]              ld_mask,
    input  logic [DATA_W-1:0]             ld_val,
    output logic [WORDS-1:0][DATA_W-1:0]  q
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (ld_mask[i]) begin
                q[i] <= ld_val;
            end else if (clr_mask[i]) begin
                q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                q[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter logic [31:0] PRI_BASE = 32'h7800_0000,
    parameter logic [31:0] EXP_BASE = 32'h7BF0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        fiq_in,
    input  logic        irq3_in,
    output logic        fiq_o,
    output logic        irq_o
);
    localparam int IDX_W = WIN_BITS - 2;
    localparam int PI_W  = $clog2(PRI_WORDS);
    localparam int EI_W  = $clog2(EXP_WORDS);

    logic                               pri_valid, exp_valid;
    logic [IDX_W-1:0]                   pri_idx, exp_idx;
    logic [PRI_WORDS-1:0][DATA_W-1:0]   pri_q;
    logic [EXP_WORDS-1:0][DATA_W-1:0]   exp_q;
    logic [PRI_WORDS-1:0]               pri_clr, pri_ld;
    logic                               fiq_lvl, irq_lvl;
    logic                               rd_stb, wr_stb, irq_rise, vec_rd, lvl_wr;

    vec_intc_decode #(.BASE(PRI_BASE), .WIN_BITS(WIN_BITS), .WORDS(PRI_WORDS)) u_pri_dec (
        .addr(bus_addr), .valid(pri_valid), .idx(pri_idx));
    vec_intc_decode #(.BASE(EXP_BASE), .WIN_BITS(WIN_BITS), .WORDS(EXP_WORDS)) u_exp_dec (
        .addr(bus_addr), .valid(exp_valid), .idx(exp_idx));

    always_comb begin
        rd_stb   = bus_sel && !bus_wr;
        wr_stb   = bus_sel && bus_wr;
        irq_rise = irq3_in && !irq_lvl;
        vec_rd   = rd_stb && pri_valid && (int'(pri_idx) == VEC_IDX);
        lvl_wr   = wr_stb && pri_valid && (int'(pri_idx) == CLR_IDX);
        pri_clr  = '0;
        pri_clr[VEC_IDX] = vec_rd;
        pri_clr[LVL_IDX] = vec_rd || lvl_wr;
        pri_ld   = '0;
        pri_ld[VEC_IDX]  = irq_rise;
    end

    vec_intc_regbank #(.WORDS(PRI_WORDS), .DATA_W(DATA_W)) u_pri_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_stb && pri_valid), .wr_idx(pri_idx[PI_W-1:0]), .wdata(bus_wdata),
        .clr_mask(pri_clr), .ld_mask(pri_ld), .ld_val(VEC_CODE), .q(pri_q));

    vec_intc_regbank #(.WORDS(EXP_WORDS), .DATA_W(DATA_W)) u_exp_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_stb && exp_valid), .wr_idx(exp_idx[EI_W-1:0]), .wdata(bus_wdata),
        .clr_mask('0), .ld_mask('0), .ld_val('0), .q(exp_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_lvl <= 1'b0;
            irq_lvl <= 1'b0;
        end else begin
            fiq_lvl <= fiq_in;
            irq_lvl <= irq3_in;
        end
    end

    always_comb begin
        fiq_o = pri_q[FIQ_EN_IDX][0] && fiq_lvl;
        irq_o = (|exp_q[IRQ_EN_IDX][31:28]) && irq_lvl;
        if (pri_valid)      bus_rdata = pri_q[pri_idx[PI_W-1:0]];
        else if (exp_valid) bus_rdata = exp_q[exp_idx[EI_W-1:0]];
        else                bus_rdata = '0;
    end

    // R2
    fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(fiq_in));
    // R3
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq3_in));
    // R4
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |=> (pri_q[VEC_IDX] == VEC_CODE));
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !irq_rise) |=> (pri_q[VEC_IDX] == '0 && pri_q[LVL_IDX] == '0));
    // R6
    lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> (pri_q[LVL_IDX] == '0));
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_valid && !exp_valid) |-> (bus_rdata == '0));
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
    localparam logic [31:0] PB = 32'h7800_0000;
    localparam logic [31:0] EB = 32'h7BF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        fiq_in = 1'b0, irq3_in = 1'b0, fiq_o, irq_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    vec_intc u_vec_intc (.*);

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic sel = 1'b1);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
        check("R1 irq_o", {31'd0, irq_o}, 32'd0);
        rd(PB + 32'h14, d); check("R1 vector", d, 32'd0);
        rd(EB + 32'h18, d); check("R1 exp enable", d, 32'd0);
    endtask

    task automatic t_words();
        logic [31:0] d;
        wr(PB + 32'h00, 32'hA5A5_5A5A); rd(PB + 32'h00, d); check("R7 primary", d, 32'hA5A5_5A5A);
        wr(EB + 32'h1C, 32'h1234_5678); rd(EB + 32'h1C, d); check("R7 expanded", d, 32'h1234_5678);
        wr(PB + 32'h30, 32'hFFFF_FFFF); rd(PB + 32'h30, d); check("R8 primary gap", d, 32'd0);
        wr(EB + 32'h20, 32'hFFFF_FFFF); rd(EB + 32'h20, d); check("R8 expanded gap", d, 32'd0);
        wr(32'h1000_0000, 32'hFFFF_FFFF); rd(32'h1000_0000, d); check("R8 outside", d, 32'd0);
        rd(PB + 32'h00, d); check("R8 no alias", d, 32'hA5A5_5A5A);
    endtask

    task automatic t_fiq();
        @(negedge clk) fiq_in = 1'b1;
        @(posedge clk) #1 check("R2 gated off", {31'd0, fiq_o}, 32'd0);
        wr(PB + 32'h10, 32'd1); check("R2 enabled", {31'd0, fiq_o}, 32'd1);
        @(negedge clk) fiq_in = 1'b0;
        @(posedge clk) #1 check("R2 line low", {31'd0, fiq_o}, 32'd0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        @(negedge clk) irq3_in = 1'b1;
        @(posedge clk) #1 check("R3 gated off", {31'd0, irq_o}, 32'd0);
        wr(EB + 32'h18, 32'h1000_0000); check("R3 nibble set", {31'd0, irq_o}, 32'd1);
        wr(EB + 32'h18, 32'h0FFF_FFFF); check("R3 nibble zero", {31'd0, irq_o}, 32'd0);
        rd(PB + 32'h14, d); check("R4 loaded", d, 32'd31);
        rd(PB + 32'h14, d); check("R5 cleared", d, 32'd0);
        rd(PB + 32'h14, d); check("R4 held no reload", d, 32'd0);
        @(negedge clk) irq3_in = 1'b0;
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr(PB + 32'h18, 32'h7);
        @(negedge clk) irq3_in = 1'b1;
        @(negedge clk) irq3_in = 1'b0;
        rd(PB + 32'h18, d); check("R9 level intact", d, 32'h7);
        rd(PB + 32'h14, d); check("R5 returns code", d, 32'd31);
        rd(PB + 32'h18, d); check("R5 level cleared", d, 32'd0);
    endtask

    task automatic t_clrlvl();
        logic [31:0] d;
        wr(PB + 32'h18, 32'h55);
        wr(PB + 32'h28, 32'hDEAD);
        rd(PB + 32'h18, d); check("R6 level cleared", d, 32'd0);
        rd(PB + 32'h28, d); check("R6 word stored", d, 32'hDEAD);
    endtask

    task automatic t_nosel();
        logic [31:0] d;
        @(negedge clk) irq3_in = 1'b1;
        @(negedge clk) irq3_in = 1'b0;
        @(negedge clk) begin bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = PB + 32'h14; end
        wr(PB + 32'h00, 32'h0, 1'b0);
        rd(PB + 32'h00, d); check("R9 unselected write", d, 32'hA5A5_5A5A);
        rd(PB + 32'h14, d); check("R9 unselected read", d, 32'd31);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(PB + 32'h18, 32'h3);
        @(negedge clk);
        irq3_in = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = PB + 32'h14;
        #1 check("R10 read value", bus_rdata, 32'd0);
        @(posedge clk); #1 bus_sel = 1'b0;
        rd(PB + 32'h18, d); check("R10 level cleared", d, 32'd0);
        rd(PB + 32'h14, d); check("R10 vector kept", d, 32'd31);
        @(negedge clk) irq3_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_words();
        t_fiq();
        t_irq_gate();
        t_ack();
        t_clrlvl();
        t_nosel();
        t_race();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule